// File: doc/BRIEF.md
# MII Receive Deframer

This block sits on the MAC side of a 4-bit media-independent interface and turns the PHY's receive nibble stream into a byte stream. It samples the receive data nibble, the data-valid strobe and the receive-error strobe on the PHY receive clock. It searches each frame for the start-of-frame delimiter and discards everything up to and including it. It then joins each pair of following nibbles into one byte.

Each output byte comes with a one-cycle valid strobe and with markers for the first and last byte of the frame. The last byte also carries two status flags. One flag says the PHY signalled a receive error at some point in the frame. The other says the frame ended with a lone nibble left over. The block locks onto a frame whether data valid rises at the first preamble nibble, as at 100 Mbps, or only at the first delimiter nibble, as at 10 Mbps. CRC checking, address filtering and clock-domain crossing belong to other blocks.

Top module: `mii_rx_deframer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `byte_valid`, `byte_first`, `byte_last`, `frame_err` and `align_err` are all 0.
- R2: The delimiter is nibble 0x5 followed directly by nibble 0xD, both with `rx_dv` high. The payload starts with the next nibble. A frame whose valid window opens on the 0x5 of the delimiter (no preamble ahead of it) is received in full.
- R3: A frame whose valid window opens with a preamble of any number of 0x5 nibbles ahead of the 0xD is received in full, and none of the preamble appears at the output.
- R4: Each output byte has the earlier payload nibble in bits 3:0 and the later one in bits 7:4.
- R5: If a nibble other than 0x5 arrives with `rx_dv` high before the delimiter is complete, the frame produces no output until `rx_dv` goes low. This includes a 0xD that has no 0x5 before it.
- R6: `byte_first` is 1 on the first byte of each frame and 0 on every other byte.
- R7: A byte is presented in the cycle after the following byte's second nibble is sampled. The final byte is presented, with `byte_last` = 1, in the cycle after `rx_dv` is first sampled low. `byte_last` is 0 on all other bytes.
- R8: If `rx_er` is sampled high in any cycle with `rx_dv` high, from the first nibble of the frame (preamble included) to its end, `frame_err` is 1 on that frame's last byte.
- R9: If the frame ends with an odd number of payload nibbles, `align_err` is 1 on the last byte. The leftover nibble is dropped.
- R10: A frame that ends before one full payload byte is assembled produces no output at all.
- R11: `frame_err` and `align_err` are 0 whenever `byte_last` is 0. `byte_first`, `byte_last` and the flags are only ever 1 together with `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error from the PHY |
| rxd | input | 4 | Receive data nibble |
| byte_valid | output | 1 | One-cycle strobe: `byte_data` holds a payload byte |
| byte_data | output | 8 | Assembled payload byte |
| byte_first | output | 1 | Marks the first byte of a frame |
| byte_last | output | 1 | Marks the last byte of a frame |
| frame_err | output | 1 | On the last byte: a receive error was seen during the frame |
| align_err | output | 1 | On the last byte: an odd trailing nibble was dropped |

## Verification
A completed byte is held back until the next byte is complete, so an ordinary byte appears one clock edge after the following byte's high nibble is sampled. The last byte appears one edge after `rx_dv` is sampled low. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which puts each result exactly one rising edge after the stimulus that causes it. Directed tests check both latencies at that point. The table-driven frames gather every strobed byte into a capture list and compare contents, count and flags once the frame has ended and the line has gone idle.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

    typedef enum logic [1:0] {
        HUNT = 2'd0,
        PAYLOAD = 2'd1,
        DISCARD = 2'd2
    } hunt_state_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              last;
        logic              err;
        logic              align;
    } rx_byte_t;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] early,
        input logic [NIB_W-1:0] late
    );
        return {late, early};
    endfunction

endpackage

// File: rtl/mii_rx_sfd_fsm.sv
module mii_rx_sfd_fsm
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dv,
    input  logic [NIB_W-1:0] nib,
    output logic             take_nib,
    output logic             frame_end
);

    hunt_state_t state_q;
    logic        seen_pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= HUNT;
            seen_pre_q <= 1'b0;
        end else begin
            case (state_q)
                HUNT: begin
                    if (!dv) begin
                        seen_pre_q <= 1'b0;
                    end else if (nib == PRE_NIB) begin
                        seen_pre_q <= 1'b1;
                    end else if (nib == SFD_NIB && seen_pre_q) begin
                        state_q    <= PAYLOAD;
                        seen_pre_q <= 1'b0;
                    end else begin
                        state_q    <= DISCARD;
                        seen_pre_q <= 1'b0;
                    end
                end
                PAYLOAD: if (!dv) state_q <= HUNT;
                DISCARD: if (!dv) state_q <= HUNT;
                default: state_q <= HUNT;
            endcase
        end
    end

    assign take_nib  = (state_q == PAYLOAD) && dv;
    assign frame_end = (state_q == PAYLOAD) && !dv;

endmodule

// File: rtl/mii_rx_packer.sv
module mii_rx_packer
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dv,
    input  logic             er,
    input  logic [NIB_W-1:0] nib,
    input  logic             take_nib,
    input  logic             frame_end,
    output rx_byte_t         out_q
);

    logic              half_q;
    logic [NIB_W-1:0]  low_q;
    logic              pend_q;
    logic              pend_first_q;
    logic [BYTE_W-1:0] pend_data_q;
    logic              err_acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q       <= 1'b0;
            low_q        <= '0;
            pend_q       <= 1'b0;
            pend_first_q <= 1'b0;
            pend_data_q  <= '0;
            err_acc_q    <= 1'b0;
            out_q        <= '0;
        end else begin
            out_q.valid <= 1'b0;
            out_q.first <= 1'b0;
            out_q.last  <= 1'b0;
            out_q.err   <= 1'b0;
            out_q.align <= 1'b0;

            // error memory spans the whole valid window, preamble included
            err_acc_q <= dv ? (err_acc_q | er) : 1'b0;

            if (take_nib) begin
                if (!half_q) begin
                    low_q  <= nib;
                    half_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    if (pend_q) begin
                        out_q.valid <= 1'b1;
                        out_q.data  <= pend_data_q;
                        out_q.first <= pend_first_q;
                    end
                    pend_data_q  <= join_nibbles(low_q, nib);
                    pend_first_q <= !pend_q;
                    pend_q       <= 1'b1;
                end
            end else if (frame_end) begin
                if (pend_q) begin
                    out_q.valid <= 1'b1;
                    out_q.data  <= pend_data_q;
                    out_q.first <= pend_first_q;
                    out_q.last  <= 1'b1;
                    out_q.err   <= err_acc_q;
                    out_q.align <= half_q;
                end
                pend_q <= 1'b0;
                half_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mii_rx_deframer.sv
module mii_rx_deframer
    import mii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_dv,
    input  logic              rx_er,
    input  logic [NIB_W-1:0]  rxd,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_first,
    output logic              byte_last,
    output logic              frame_err,
    output logic              align_err
);

    logic     take_nib;
    logic     frame_end;
    rx_byte_t out_b;

    mii_rx_sfd_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .dv        (rx_dv),
        .nib       (rxd),
        .take_nib  (take_nib),
        .frame_end (frame_end)
    );

    mii_rx_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .dv        (rx_dv),
        .er        (rx_er),
        .nib       (rxd),
        .take_nib  (take_nib),
        .frame_end (frame_end),
        .out_q     (out_b)
    );

    assign byte_valid = out_b.valid;
    assign byte_data  = out_b.data;
    assign byte_first = out_b.first;
    assign byte_last  = out_b.last;
    assign frame_err  = out_b.err;
    assign align_err  = out_b.align;

endmodule

// File: rtl/mii_rx_deframer_chk.sv
module mii_rx_deframer_chk (
    input logic clk,
    input logic rst,
    input logic rx_dv,
    input logic byte_valid,
    input logic byte_first,
    input logic byte_last,
    input logic frame_err,
    input logic align_err
);

    // R11: status flags only on the last byte
    a_r11_flags_on_last: assert property (@(posedge clk) disable iff (rst)
        (frame_err || align_err) |-> (byte_valid && byte_last));

    // R11: markers only with a valid byte
    a_r11_marks_need_valid: assert property (@(posedge clk) disable iff (rst)
        (byte_first || byte_last) |-> byte_valid);

    // R7: last byte follows a cycle where rx_dv was sampled low
    a_r7_last_after_dv_low: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_last) |-> !$past(rx_dv));

    // R7: ordinary bytes are emitted only while the frame is still running
    a_r7_mid_during_dv: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_last) |-> $past(rx_dv));

    // R1: no output on the cycle that follows reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !byte_valid);

endmodule

bind mii_rx_deframer mii_rx_deframer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_dv      (rx_dv),
    .byte_valid (byte_valid),
    .byte_first (byte_first),
    .byte_last  (byte_last),
    .frame_err  (frame_err),
    .align_err  (align_err)
);

// File: tb/mii_rx_deframer_test.sv
module mii_rx_deframer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_dv = 1'b0;
    logic       rx_er = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       byte_valid, byte_first, byte_last, frame_err, align_err;
    logic [7:0] byte_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mii_rx_deframer uut (
        .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
        .byte_last(byte_last), .frame_err(frame_err), .align_err(align_err)
    );

    // capture of strobed bytes: {data, first, last, err, align}
    logic [11:0] cap [16];
    int cap_n = 0;

    always @(negedge clk) begin
        if (!rst && byte_valid && cap_n < 16) begin
            cap[cap_n] = {byte_data, byte_first, byte_last, frame_err, align_err};
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic dv, input logic er, input logic [3:0] n);
        @(negedge clk);
        rx_dv = dv; rx_er = er; rxd = n;
    endtask

    // [15:12] count of 0x5 nibbles (0: frame opens on 0xD), [11:8] payload bytes,
    // [7] odd trailing nibble, [6] stray 0xA first, [5:0] nibble index with rx_er (63: none)
    localparam logic [15:0] VEC [8] = '{
        {4'd1,  4'd4, 1'b0, 1'b0, 6'd63},  // R2: valid opens on delimiter
        {4'd15, 4'd3, 1'b0, 1'b0, 6'd63},  // R3: long preamble
        {4'd7,  4'd1, 1'b1, 1'b0, 6'd63},  // R9: odd nibble
        {4'd15, 4'd5, 1'b0, 1'b0, 6'd20},  // R8: error in payload
        {4'd0,  4'd3, 1'b0, 1'b0, 6'd63},  // R5: 0xD without 0x5
        {4'd4,  4'd2, 1'b0, 1'b1, 6'd63},  // R5: stray nibble
        {4'd3,  4'd0, 1'b1, 1'b0, 6'd63},  // R10: single nibble only
        {4'd1,  4'd2, 1'b0, 1'b0, 6'd0}    // R8: error on first nibble
    };

    function automatic logic [7:0] pay(input int v, input int i);
        return 8'((v * 37 + i * 29 + 11) & 8'hFF);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", byte_valid, 0);
        chk("R1", "flags in reset", {byte_first, byte_last, frame_err, align_err}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", byte_valid, 0);

        // table-driven frames
        for (int v = 0; v < 8; v++) begin
            int npre, nb, idx, expn;
            bit odd, bad, want_err;
            npre = int'(VEC[v][15:12]); nb = int'(VEC[v][11:8]);
            odd = VEC[v][7]; bad = VEC[v][6];
            cap_n = 0; idx = 0;
            want_err = (VEC[v][5:0] != 6'd63);
            if (bad) begin put(1, VEC[v][5:0] == 6'(idx), 4'hA); idx++; end
            for (int p = 0; p < npre; p++) begin put(1, VEC[v][5:0] == 6'(idx), 4'h5); idx++; end
            put(1, VEC[v][5:0] == 6'(idx), 4'hD); idx++;
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d;
                d = pay(v, b);
                put(1, VEC[v][5:0] == 6'(idx), d[3:0]); idx++;
                put(1, VEC[v][5:0] == 6'(idx), d[7:4]); idx++;
            end
            if (odd) begin put(1, VEC[v][5:0] == 6'(idx), 4'h3); idx++; end
            put(0, 0, 4'h0);
            repeat (3) @(negedge clk);
            expn = (bad || npre == 0) ? 0 : nb;
            chk((expn == 0) ? ((nb == 0) ? "R10" : "R5") : ((npre > 1) ? "R3" : "R2"),
                $sformatf("vec %0d byte count", v), cap_n, expn);
            for (int b = 0; b < expn && b < cap_n; b++) begin
                bit lastb;
                lastb = (b == expn - 1);
                chk("R4", $sformatf("vec %0d byte %0d data", v, b), cap[b][11:4], pay(v, b));
                chk("R6", $sformatf("vec %0d byte %0d first", v, b), cap[b][3], b == 0);
                chk("R7", $sformatf("vec %0d byte %0d last", v, b), cap[b][2], lastb);
                chk(lastb ? "R8" : "R11", $sformatf("vec %0d byte %0d err", v, b), cap[b][1], lastb && want_err);
                chk(lastb ? "R9" : "R11", $sformatf("vec %0d byte %0d align", v, b), cap[b][0], lastb && odd);
            end
        end

        // R7: exact latency of an ordinary byte and of the last byte
        put(1, 0, 4'h5); put(1, 0, 4'hD);
        put(1, 0, 4'hA); put(1, 0, 4'hA);
        put(1, 0, 4'h3); put(1, 0, 4'hB);
        @(negedge clk);
        chk("R7", "mid byte strobe", byte_valid, 1);
        chk("R7", "mid byte data", byte_data, 8'hAA);
        chk("R7", "mid byte not last", byte_last, 0);
        rx_dv = 0; rxd = 4'h0;
        @(negedge clk);
        chk("R7", "last byte strobe", {byte_valid, byte_last}, 2'b11);
        chk("R4", "last byte data", byte_data, 8'hB3);
        @(negedge clk);
        chk("R7", "quiet after last", byte_valid, 0);

        // R5: non-preamble nibble after 0x5 kills the frame
        cap_n = 0;
        put(1, 0, 4'h5); put(1, 0, 4'h7); put(1, 0, 4'h5); put(1, 0, 4'hD);
        put(1, 0, 4'h1); put(1, 0, 4'h2); put(1, 0, 4'h3); put(1, 0, 4'h4);
        put(0, 0, 4'h0);
        repeat (3) @(negedge clk);
        chk("R5", "late delimiter after stray", cap_n, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule